// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator

The block is a small arithmetic helper on a processor bus. It keeps two accumulators and three base values. Each of two lanes takes an accumulator, shifts it right, keeps a chosen contiguous field of bits and can sign-extend that field. The lane's field is then added to its base to give a lane result. A third result adds both lane fields to the third base. Software reads the results without side effects, or it "pops" them. A pop returns the same value and, in the same access, loads each accumulator from a lane result. A run of pops therefore steps the accumulators through a fixed recurrence, one step per read.

Each lane has a control word. The control word can feed the lane from the opposite accumulator. It can route the lane's pop write-back to the opposite accumulator. It can also add the whole unshifted input to the base instead of the extracted field. A separate write alias per accumulator adds the written value to that accumulator instead of replacing it. Bus accesses take one cycle. Read data is combinational from the current state, and every write or pop takes effect at the clock edge that closes the access.

Top module: `interp_unit`

## Requirements
- R1: After reset both accumulators and all three bases read 0. Both control words read 0x0000_7C00: field top bit 31, every other field 0.
- R2: Word addresses are: 0 ACC0, 1 ACC1, 2 BASE0, 3 BASE1, 4 BASE2, 5-7 PEEK0-2, 8-10 POP0-2, 11 CTRL0, 12 CTRL1, 13 ADD0, 14 ADD1. A write to a storage register shows on a read in the next access.
- R3: A write to ADD0 or ADD1 adds the data to ACC0 or ACC1 modulo 2^32.
- R4: Control word layout: bits 4:0 shift, 9:5 field low bit, 14:10 field high bit. A lane's field is (input >> shift) with only bits low..high kept. When low > high the field is 0.
- R5: With control bit 15 set and field bit [high] equal to 1, all bits above high become 1.
- R6: With control bit 16 set, the lane's input is the other lane's accumulator.
- R7: Lane result k (k = 0, 1) is BASEk + field, modulo 2^32. With control bit 18 set, the unshifted and unmasked input is added instead of the field.
- R8: Result 2 is BASE2 + field0 + field1, modulo 2^32. The fields are never raw, whatever bit 18 is set to.
- R9: A read of PEEKk returns result k and changes no state.
- R10: A read of POPk returns the same value as PEEKk would. At the edge closing that read, both accumulators are loaded from lane results that were computed before the edge.
- R11: With control bit 17 of lane j set, a pop loads accumulator j from the other lane's result instead of lane j's own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when not reading |

## Verification
A pop returns a value and rewrites the accumulators in the same access. The returned value must come from the state before the edge, and both accumulators must update together from those old results. The bench sets both lanes to cross their write-back and pops. It then checks that the value returned uses the old accumulators and that the two accumulators swapped their lane results, with neither seeing the other's new value. A run of ten pops in the default setup checks that each return value is one step ahead of the previous one.

// File: rtl/interp_pkg.sv
package interp_pkg;
  parameter int unsigned DW     = 32;
  parameter int unsigned AW     = 4;
  localparam int unsigned SW    = $clog2(DW);
  localparam int unsigned LANES = 2;
  localparam int unsigned NBASE = LANES + 1;

  localparam logic [AW-1:0] A_ACC0  = AW'(0);
  localparam logic [AW-1:0] A_ACC1  = AW'(1);
  localparam logic [AW-1:0] A_BASE0 = AW'(2);
  localparam logic [AW-1:0] A_BASE1 = AW'(3);
  localparam logic [AW-1:0] A_BASE2 = AW'(4);
  localparam logic [AW-1:0] A_PEEK0 = AW'(5);
  localparam logic [AW-1:0] A_PEEK1 = AW'(6);
  localparam logic [AW-1:0] A_PEEK2 = AW'(7);
  localparam logic [AW-1:0] A_POP0  = AW'(8);
  localparam logic [AW-1:0] A_POP1  = AW'(9);
  localparam logic [AW-1:0] A_POP2  = AW'(10);
  localparam logic [AW-1:0] A_CTRL0 = AW'(11);
  localparam logic [AW-1:0] A_CTRL1 = AW'(12);
  localparam logic [AW-1:0] A_ADD0  = AW'(13);
  localparam logic [AW-1:0] A_ADD1  = AW'(14);

  typedef struct packed {
    logic          add_raw;
    logic          xresult;
    logic          xinput;
    logic          sext;
    logic [SW-1:0] hi;
    logic [SW-1:0] lo;
    logic [SW-1:0] shift;
  } lane_ctrl_t;

  localparam int unsigned CTRL_W = $bits(lane_ctrl_t);

  localparam lane_ctrl_t CTRL_RST = '{add_raw: 1'b0, xresult: 1'b0, xinput: 1'b0,
                                      sext: 1'b0, hi: SW'(DW-1), lo: '0, shift: '0};

  typedef struct packed {
    logic [LANES-1:0] wr_acc;
    logic [LANES-1:0] add_acc;
    logic [NBASE-1:0] wr_base;
    logic [LANES-1:0] wr_ctrl;
    logic             pop;
    logic             rd;
  } strobes_t;
endpackage

// File: rtl/interp_decode.sv
module interp_decode
  import interp_pkg::*;
(
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output strobes_t      stb_o
);
  logic wr;
  assign wr = req_i & we_i;

  always_comb begin
    stb_o    = '0;
    stb_o.rd = req_i & ~we_i;
    unique case (addr_i)
      A_ACC0:  stb_o.wr_acc[0]  = wr;
      A_ACC1:  stb_o.wr_acc[1]  = wr;
      A_BASE0: stb_o.wr_base[0] = wr;
      A_BASE1: stb_o.wr_base[1] = wr;
      A_BASE2: stb_o.wr_base[2] = wr;
      A_CTRL0: stb_o.wr_ctrl[0] = wr;
      A_CTRL1: stb_o.wr_ctrl[1] = wr;
      A_ADD0:  stb_o.add_acc[0] = wr;
      A_ADD1:  stb_o.add_acc[1] = wr;
      A_POP0, A_POP1, A_POP2: stb_o.pop = req_i & ~we_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
(
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] base_i,
  input  lane_ctrl_t    ctrl_i,
  output logic [DW-1:0] field_o,
  output logic [DW-1:0] result_o
);
  logic [DW-1:0] shifted, keep, kept, ext;
  logic          sign_bit;

  assign shifted  = in_i >> ctrl_i.shift;
  assign kept     = shifted & keep;
  assign sign_bit = kept[ctrl_i.hi];

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      keep[i] = (SW'(i) >= ctrl_i.lo) && (SW'(i) <= ctrl_i.hi);
      ext[i]  = ctrl_i.sext && sign_bit && (SW'(i) > ctrl_i.hi);
    end
  end

  assign field_o  = kept | ext;
  // raw mode bypasses shift/mask for the lane sum only
  assign result_o = base_i + (ctrl_i.add_raw ? in_i : field_o);
endmodule

// File: rtl/interp_rd_mux.sv
module interp_rd_mux
  import interp_pkg::*;
(
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] acc0_i,
  input  logic [DW-1:0] acc1_i,
  input  logic [DW-1:0] base0_i,
  input  logic [DW-1:0] base1_i,
  input  logic [DW-1:0] base2_i,
  input  logic [DW-1:0] res0_i,
  input  logic [DW-1:0] res1_i,
  input  logic [DW-1:0] res2_i,
  input  lane_ctrl_t    ctrl0_i,
  input  lane_ctrl_t    ctrl1_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_ACC0:                  rdata_o = acc0_i;
        A_ACC1:                  rdata_o = acc1_i;
        A_BASE0:                 rdata_o = base0_i;
        A_BASE1:                 rdata_o = base1_i;
        A_BASE2:                 rdata_o = base2_i;
        A_PEEK0, A_POP0:         rdata_o = res0_i;
        A_PEEK1, A_POP1:         rdata_o = res1_i;
        A_PEEK2, A_POP2:         rdata_o = res2_i;
        A_CTRL0:                 rdata_o = DW'(ctrl0_i);
        A_CTRL1:                 rdata_o = DW'(ctrl1_i);
        default:                 rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/interp_unit.sv
module interp_unit
  import interp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  strobes_t      stb;
  logic [DW-1:0] acc_q   [LANES];
  logic [DW-1:0] base_q  [NBASE];
  lane_ctrl_t    ctrl_q  [LANES];
  logic [DW-1:0] lane_in [LANES];
  logic [DW-1:0] field   [LANES];
  logic [DW-1:0] res     [NBASE];

  interp_decode u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .stb_o  (stb)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int unsigned OTH = LANES - 1 - j;

    assign lane_in[j] = ctrl_q[j].xinput ? acc_q[OTH] : acc_q[j];

    interp_lane u_lane (
      .in_i     (lane_in[j]),
      .base_i   (base_q[j]),
      .ctrl_i   (ctrl_q[j]),
      .field_o  (field[j]),
      .result_o (res[j])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[j]  <= '0;
        ctrl_q[j] <= CTRL_RST;
      end else begin
        if (stb.wr_acc[j])       acc_q[j] <= wdata_i;
        else if (stb.add_acc[j]) acc_q[j] <= acc_q[j] + wdata_i;
        else if (stb.pop)        acc_q[j] <= ctrl_q[j].xresult ? res[OTH] : res[j];
        if (stb.wr_ctrl[j])      ctrl_q[j] <= lane_ctrl_t'(wdata_i[CTRL_W-1:0]);
      end
    end
  end

  assign res[2] = base_q[2] + field[0] + field[1];

  for (genvar k = 0; k < NBASE; k++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             base_q[k] <= '0;
      else if (stb.wr_base[k]) base_q[k] <= wdata_i;
    end
  end

  interp_rd_mux u_rd (
    .rd_i    (stb.rd),
    .addr_i  (addr_i),
    .acc0_i  (acc_q[0]),
    .acc1_i  (acc_q[1]),
    .base0_i (base_q[0]),
    .base1_i (base_q[1]),
    .base2_i (base_q[2]),
    .res0_i  (res[0]),
    .res1_i  (res[1]),
    .res2_i  (res[2]),
    .ctrl0_i (ctrl_q[0]),
    .ctrl1_i (ctrl_q[1]),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/interp_unit_chk.sv
module interp_unit_chk
  import interp_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] acc0,
  input logic [DW-1:0] acc1,
  input logic [DW-1:0] base0,
  input logic [DW-1:0] res0,
  input logic [DW-1:0] res1,
  input logic [DW-1:0] res2,
  input logic          xr0,
  input logic          xr1
);
  logic rd, is_peek, is_pop;
  assign rd      = req_i && !we_i;
  assign is_peek = rd && (addr_i == A_PEEK0 || addr_i == A_PEEK1 || addr_i == A_PEEK2);
  assign is_pop  = rd && (addr_i == A_POP0 || addr_i == A_POP1 || addr_i == A_POP2);

  a_r9_peek_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_peek |=> ($stable(acc0) && $stable(acc1)));

  a_r3_add_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_ADD0) |=> acc0 == $past(acc0) + $past(wdata_i));

  a_r2_base_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_BASE0) |=> base0 == $past(wdata_i));

  a_r10_pop_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop || is_peek) |->
      rdata_o == ((addr_i == A_POP0 || addr_i == A_PEEK0) ? res0 :
                  (addr_i == A_POP1 || addr_i == A_PEEK1) ? res1 : res2));

  a_r11_pop_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pop |=> (acc0 == $past(xr0 ? res1 : res0)) && (acc1 == $past(xr1 ? res0 : res1)));
endmodule

bind interp_unit interp_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .acc0    (acc_q[0]),
  .acc1    (acc_q[1]),
  .base0   (base_q[0]),
  .res0    (res[0]),
  .res1    (res[1]),
  .res2    (res[2]),
  .xr0     (ctrl_q[0].xresult),
  .xr1     (ctrl_q[1].xresult)
);

// File: tb/interp_unit_tb.sv
`timescale 1ns/1ps
module interp_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [3:0] ACC0 = 0, ACC1 = 1, BASE0 = 2, BASE1 = 3, BASE2 = 4,
                         PEEK0 = 5, PEEK1 = 6, PEEK2 = 7, POP0 = 8, POP1 = 9, POP2 = 10,
                         CTRL0 = 11, CTRL1 = 12, ADD0 = 13, ADD1 = 14;
  localparam logic [31:0] CTRL_DEF = 32'h0000_7C00;

  always #2.5 clk_i = ~clk_i;

  interp_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [31:0] mk_ctrl(int sh, int lo, int hi, bit sx, bit xi, bit xr, bit raw);
    return {13'd0, raw, xr, xi, sx, 5'(hi), 5'(lo), 5'(sh)};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic clear_all();
    wr(CTRL0, CTRL_DEF); wr(CTRL1, CTRL_DEF);
    wr(ACC0, 0); wr(ACC1, 0); wr(BASE0, 0); wr(BASE1, 0); wr(BASE2, 0);
  endtask

  task automatic t_reset();
    rd_chk("R1 acc0", ACC0, 0);
    rd_chk("R1 acc1", ACC1, 0);
    rd_chk("R1 base2", BASE2, 0);
    rd_chk("R1 ctrl0", CTRL0, CTRL_DEF);
    rd_chk("R1 ctrl1", CTRL1, CTRL_DEF);
  endtask

  task automatic t_regs();
    wr(BASE1, 32'hCAFE_0001);
    rd_chk("R2 base1 next access", BASE1, 32'hCAFE_0001);
    wr(ACC1, 32'h1234_5678);
    rd_chk("R2 acc1", ACC1, 32'h1234_5678);
    rd_chk("R2 unmapped reads 0", 4'd15, 0);
    clear_all();
  endtask

  task automatic t_add();
    wr(ACC1, 5); wr(ADD1, 7);
    rd_chk("R3 add", ACC1, 12);
    wr(ACC0, 32'hFFFF_FFFF); wr(ADD0, 2);
    rd_chk("R3 add wrap", ACC0, 1);
    clear_all();
  endtask

  task automatic t_times_table();
    logic [31:0] d;
    wr(BASE0, 9);
    for (int i = 0; i < 10; i++) begin
      rd(POP0, d);
      check("R10 pop step", d, 32'(9 * (i + 1)));
    end
    rd_chk("R10 acc0 after pops", ACC0, 90);
    clear_all();
  endtask

  task automatic t_field();
    wr(ACC0, 32'h1234_5678); wr(BASE0, 32'h100);
    wr(CTRL0, mk_ctrl(4, 0, 7, 0, 0, 0, 0));
    rd_chk("R4 shift+mask", PEEK0, 32'h167);
    wr(CTRL0, mk_ctrl(0, 8, 15, 0, 0, 0, 0));
    rd_chk("R4 mid field", PEEK0, 32'h5700);
    wr(CTRL0, mk_ctrl(0, 5, 2, 0, 0, 0, 0));
    rd_chk("R4 empty field", PEEK0, 32'h100);
    clear_all();
  endtask

  task automatic t_sign();
    wr(ACC0, 32'hF0);
    wr(CTRL0, mk_ctrl(4, 0, 3, 1, 0, 0, 0));
    rd_chk("R5 sign extend", PEEK0, 32'hFFFF_FFFF);
    wr(CTRL0, mk_ctrl(4, 0, 3, 0, 0, 0, 0));
    rd_chk("R5 unsigned", PEEK0, 32'hF);
    wr(ACC0, 32'h70);
    wr(CTRL0, mk_ctrl(4, 0, 3, 1, 0, 0, 0));
    rd_chk("R5 positive no extend", PEEK0, 32'h7);
    clear_all();
  endtask

  task automatic t_cross_in();
    wr(ACC0, 32'h55); wr(ACC1, 32'h11);
    wr(CTRL1, mk_ctrl(0, 0, 31, 0, 1, 0, 0));
    rd_chk("R6 cross input", PEEK1, 32'h55);
    clear_all();
  endtask

  task automatic t_raw();
    wr(ACC0, 32'h1234); wr(BASE0, 1);
    wr(CTRL0, mk_ctrl(8, 0, 3, 0, 0, 0, 1));
    rd_chk("R7 raw add", PEEK0, 32'h1235);
    rd_chk("R8 result2 uses field not raw", PEEK2, 32'h2);
    wr(CTRL0, CTRL_DEF);
    wr(BASE0, 32'hFFFF_FFFF); wr(ACC0, 2);
    rd_chk("R7 wrap", PEEK0, 1);
    clear_all();
  endtask

  task automatic t_res2();
    wr(ACC0, 3); wr(ACC1, 4); wr(BASE2, 100);
    rd_chk("R8 sum", PEEK2, 107);
    wr(BASE2, 32'hFFFF_FFFF);
    rd_chk("R8 wrap", PEEK2, 6);
    clear_all();
  endtask

  task automatic t_peek();
    wr(ACC0, 7); wr(ACC1, 8); wr(BASE0, 1); wr(BASE1, 2);
    rd_chk("R9 peek0", PEEK0, 8);
    rd_chk("R9 peek0 repeat", PEEK0, 8);
    rd_chk("R9 peek2", PEEK2, 15);
    rd_chk("R9 acc0 unchanged", ACC0, 7);
    rd_chk("R9 acc1 unchanged", ACC1, 8);
    clear_all();
  endtask

  task automatic t_pop2();
    wr(ACC0, 1); wr(ACC1, 2); wr(BASE0, 10); wr(BASE1, 20);
    rd_chk("R10 pop2 value", POP2, 3);
    rd_chk("R10 acc0 written back", ACC0, 11);
    rd_chk("R10 acc1 written back", ACC1, 22);
    clear_all();
  endtask

  task automatic t_cross_result();
    wr(ACC0, 10); wr(ACC1, 20); wr(BASE0, 1); wr(BASE1, 2);
    wr(CTRL0, mk_ctrl(0, 0, 31, 0, 0, 1, 0));
    wr(CTRL1, mk_ctrl(0, 0, 31, 0, 0, 1, 0));
    rd_chk("R10 pop1 uses old state", POP1, 22);
    rd_chk("R11 acc0 from lane1", ACC0, 22);
    rd_chk("R11 acc1 from lane0", ACC1, 11);
    clear_all();
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_regs();
    t_add();
    t_times_table();
    t_field();
    t_sign();
    t_cross_in();
    t_raw();
    t_res2();
    t_peek();
    t_pop2();
    t_cross_result();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule